// File: doc/BRIEF.md
# Receive Elastic Buffer with Whole-Frame Drop Counting

This block sits between a receive stream coming out of a MAC and a host-side data FIFO further down the path. Each incoming word carries a start-of-frame and an end-of-frame marker. Words are first written into a small internal elastic FIFO. Complete frames drain from it to the downstream FIFO whenever that FIFO signals it can take data. While the downstream FIFO stays full, words pile up in the elastic store. The fill level of the elastic store is not visible outside the block, and it does not count toward any threshold that the downstream FIFO keeps.

The receive side cannot be stalled, so its interface has no ready signal. Every cycle with `rx_valid` high delivers one word, and that word must either be stored or be thrown away. If a word arrives while the store already holds `DEPTH` words, the block does not drop just that word. It rewinds the write pointer to the start of the frame, so the whole frame disappears, and it then enters a discard state. In the discard state every newly starting frame is also dropped whole. The discard state ends only at a frame start, and only once the free space is at least `MAX_FRAME` words. Each lost frame adds one to a saturating counter, and reading that counter clears it.

The output side is valid/ready. `tx_valid` goes high only when at least one complete frame is held, and `tx_last` marks the final word of each frame. While `tx_valid` is high and `tx_ready` is low, the word on offer and its marker stay unchanged. A word moves only on a cycle where both signals are high. The downstream side may drop `tx_ready` at any time, with no other effect.

Top module: `rx_elastic_buf`

## Requirements
- R1: Words that are accepted leave in arrival order on `tx_data`. `tx_last` is 1 exactly on the word that entered with `rx_last` = 1.
- R2: No word of a frame is offered (`tx_valid` stays 0 for it) until the final word of that frame has been stored. The frame becomes visible in the cycle after that final word is clocked in.
- R3: While `tx_ready` is 0, the store keeps up to `DEPTH` words with no loss. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` keep their values.
- R4: A word that arrives while `DEPTH` words are held removes every stored word of its own frame, and frames that are already complete stay intact. This loss adds one to the drop counter.
- R5: After such an overflow, the rest of that frame's words are ignored. Every frame that starts (`rx_first` = 1) while free space is below `MAX_FRAME` words is also dropped whole, and each one adds one to the counter.
- R6: The discard state ends at the first frame start where free space is at least `MAX_FRAME` words. That frame, and the frames after it, are then stored normally.
- R7: The drop counter is `CNT_W` bits wide (32 by default). It saturates at all-ones and never wraps.
- R8: A one-cycle pulse on `drop_clr` sets the counter to 0 on the next cycle. If a frame is dropped in the same cycle, the counter reads 1 instead.
- R9: A word with `rx_first` = 0 that arrives outside any frame is ignored. It is never offered and is not counted.
- R10: After reset, `tx_valid` is 0 and `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive word present this cycle (no stall possible) |
| rx_data | input | DATA_W | Receive word |
| rx_first | input | 1 | Word is the first of a frame |
| rx_last | input | 1 | Word is the last of a frame |
| tx_valid | output | 1 | A word of a complete frame is offered |
| tx_ready | input | 1 | Downstream FIFO can take a word |
| tx_data | output | DATA_W | Offered word |
| tx_last | output | 1 | Offered word ends its frame |
| drop_clr | input | 1 | Read strobe; clears the drop counter |
| drop_count | output | CNT_W | Saturating count of frames lost |

## Verification
The bench fills the store exactly to `DEPTH` and then pushes one more word. A design that dropped only that word would forward a truncated frame. A design that rewound too far would lose frames that were already complete. Free space is brought to `MAX_FRAME` minus one, and then to exactly `MAX_FRAME`, before a new frame starts. This exposes an off-by-one in the re-entry test: such a design either stays in discard too long or accepts a frame it has no room for. The bench also drives the counter past its limit, which shows a counter that wraps to zero, and it pulses a clear in the same cycle as a drop, which shows a clear that loses that drop. A stray continuation word and a frame whose words are held back check that nothing partial or orphaned ever appears on the output.

// File: rtl/rx_elastic_buf_pkg.sv
package rx_elastic_buf_pkg;
  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_DROP = 1'b1
  } rxeb_mode_e;
endpackage

// File: rtl/rxeb_store.sv
module rxeb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  typedef struct packed {
    logic              last;
    logic [DATA_W-1:0] data;
  } slot_t;

  slot_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= '{last: wr_last, data: wr_data};
  end

  assign rd_data = mem[rd_addr].data;
  assign rd_last = mem[rd_addr].last;
endmodule

// File: rtl/rxeb_ctrl.sv
module rxeb_ctrl
  import rx_elastic_buf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_FRAME = 8,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          pop,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          has_frame,
  output logic          drop_pulse
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ROOM_LVL = (AW+1)'(MAX_FRAME);

  logic [AW:0] wr_cur_q, wr_cur_d;
  logic [AW:0] commit_q, commit_d;
  logic [AW:0] rd_q;
  logic        in_frame_q, in_frame_d;
  rxeb_mode_e  mode_q, mode_d;

  logic [AW:0] used, free_committed;
  logic        full, take_word;

  assign used           = wr_cur_q - rd_q;
  assign full           = (used == FULL_LVL);
  assign free_committed = FULL_LVL - (commit_q - rd_q);

  always_comb begin
    wr_cur_d   = wr_cur_q;
    commit_d   = commit_q;
    in_frame_d = in_frame_q;
    mode_d     = mode_q;
    drop_pulse = 1'b0;
    take_word  = 1'b0;

    if (in_valid) begin
      if (mode_q == MODE_PASS) begin
        if (in_first || in_frame_q) begin
          if (full) begin
            wr_cur_d   = commit_q;
            in_frame_d = 1'b0;
            mode_d     = MODE_DROP;
            drop_pulse = 1'b1;
          end else begin
            take_word = 1'b1;
          end
        end
      end else if (in_first) begin
        if (free_committed >= ROOM_LVL) begin
          mode_d    = MODE_PASS;
          take_word = 1'b1;
        end else begin
          drop_pulse = 1'b1;
        end
      end
    end

    if (take_word) begin
      wr_cur_d = wr_cur_q + 1'b1;
      if (in_last) begin
        commit_d   = wr_cur_q + 1'b1;
        in_frame_d = 1'b0;
      end else begin
        in_frame_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cur_q   <= '0;
      commit_q   <= '0;
      rd_q       <= '0;
      in_frame_q <= 1'b0;
      mode_q     <= MODE_PASS;
    end else begin
      wr_cur_q   <= wr_cur_d;
      commit_q   <= commit_d;
      in_frame_q <= in_frame_d;
      mode_q     <= mode_d;
      if (pop) rd_q <= rd_q + 1'b1;
    end
  end

  assign wr_en     = take_word;
  assign wr_addr   = wr_cur_q[AW-1:0];
  assign rd_addr   = rd_q[AW-1:0];
  assign has_frame = (rd_q != commit_q);

  // R3: the store never holds more than DEPTH words
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= FULL_LVL);

  // R4: an overflow rewinds the write pointer to the frame start
  a_r4_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pulse && mode_q == MODE_PASS) |=> (wr_cur_q == commit_q && mode_q == MODE_DROP));

  // R5: continuation words in discard state write nothing
  a_r5_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DROP && in_valid && !in_first) |=> $stable(wr_cur_q));

  // R2: a frame is offered only once committed, and reads never pass the commit point
  a_r2_read_behind_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_q - rd_q) <= used);
endmodule

// File: rtl/rxeb_drop_cnt.sv
module rxeb_drop_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= inc ? CNT_W'(1) : '0;
    end else if (inc && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

  // R7: once saturated the counter holds until cleared
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr) |=> cnt_q == TOP);

  // R8: a clear with no concurrent drop yields zero
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt_q == '0);
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int MAX_FRAME = 8,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_first,
  input  logic              rx_last,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              drop_clr,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_en, drop_pulse, has_frame;
  logic [AW-1:0] wr_addr, rd_addr;

  rxeb_ctrl #(.DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_first   (rx_first),
    .in_last    (rx_last),
    .pop        (tx_valid && tx_ready),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .has_frame  (has_frame),
    .drop_pulse (drop_pulse)
  );

  rxeb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (rx_data),
    .wr_last (rx_last),
    .rd_addr (rd_addr),
    .rd_data (tx_data),
    .rd_last (tx_last)
  );

  rxeb_drop_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_pulse),
    .clr   (drop_clr),
    .count (drop_count)
  );

  assign tx_valid = has_frame;

  // R3: an offered word is held steady while the downstream side stalls
  a_r3_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

// File: tb/rx_elastic_buf_tb.sv
module rx_elastic_buf_tb;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int MAXF = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic tx_ready = 1'b0, drop_clr = 1'b0;
  logic tx_valid, tx_last;
  logic [DW-1:0] tx_data;
  logic [CW-1:0] drop_count;

  always #4 clk = ~clk;

  rx_elastic_buf #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_FRAME(MAXF), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_first(rx_first), .rx_last(rx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .drop_clr(drop_clr), .drop_count(drop_count)
  );

  int tests = 0;
  int fails = 0;
  logic [DW:0] got [256];
  logic [DW:0] exp_q [256];
  int n_got = 0;
  int n_exp = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_ready && n_got < 256) begin
      got[n_got] = {tx_last, tx_data};
      n_got++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send_frame(input int base, input int len, input bit keep);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = DW'(base + i);
      rx_first = (i == 0);
      rx_last  = (i == len - 1);
      if (keep) begin
        exp_q[n_exp] = {rx_last, rx_data};
        n_exp++;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    tx_ready = 1'b1;
    repeat (DEPTH + 4) @(negedge clk);
    tx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk(n_got == n_exp, {req, " word count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      chk(got[i] == exp_q[i], {req, " word"}, int'(got[i]), int'(exp_q[i]));
    n_got = 0;
    n_exp = 0;
  endtask

  task automatic pop_n(input int n);
    @(negedge clk);
    tx_ready = 1'b1;
    repeat (n) @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic clear_cnt();
    @(negedge clk);
    drop_clr = 1'b1;
    @(negedge clk);
    drop_clr = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    chk(tx_valid == 1'b0, "R10 tx_valid", int'(tx_valid), 0);
    chk(drop_count == '0, "R10 drop_count", int'(drop_count), 0);
  endtask

  task automatic t_pass();
    tx_ready = 1'b1;
    // R2: nothing is offered while the frame is still arriving
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = DW'(8'h10 + i);
      rx_first = (i == 0); rx_last = (i == 2);
      exp_q[n_exp] = {rx_last, rx_data}; n_exp++;
      #1;
      chk(tx_valid == 1'b0, "R2 no partial frame", int'(tx_valid), 0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
    chk(tx_valid == 1'b1, "R2 frame visible after last word", int'(tx_valid), 1);
    send_frame(8'h20, 1, 1'b1);
    send_frame(8'h30, 5, 1'b1);
    repeat (10) @(negedge clk);
    tx_ready = 1'b0;
    compare("R1 pass-through");
  endtask

  task automatic t_stall();
    send_frame(8'h40, 4, 1'b1);
    send_frame(8'h50, 4, 1'b1);
    @(negedge clk); #1;
    chk(tx_valid == 1'b1 && tx_data == 8'h40, "R3 head held", int'(tx_data), 8'h40);
    repeat (3) @(negedge clk);
    #1;
    chk(tx_valid == 1'b1 && tx_data == 8'h40, "R3 head stable", int'(tx_data), 8'h40);
    drain();
    compare("R3 stalled frames");
    chk(drop_count == '0, "R3 no drops", int'(drop_count), 0);
  endtask

  task automatic t_overflow();
    send_frame(8'h60, 4, 1'b1);
    send_frame(8'h70, 4, 1'b1);
    send_frame(8'h80, 4, 1'b1);
    send_frame(8'h90, 6, 1'b0);
    #1;
    chk(drop_count == 1, "R4 overflow counted once", int'(drop_count), 1);
    send_frame(8'hA0, 3, 1'b0);
    #1;
    chk(drop_count == 2, "R5 frame dropped in discard", int'(drop_count), 2);
    drain();
    send_frame(8'hB0, 2, 1'b1);
    drain();
    compare("R4 R6 surviving frames");
    clear_cnt();
    #1;
    chk(drop_count == '0, "R8 clear", int'(drop_count), 0);
  endtask

  task automatic t_threshold();
    send_frame(8'hC0, 8, 1'b1);
    send_frame(8'hC8, 8, 1'b1);
    send_frame(8'hD0, 1, 1'b0);
    pop_n(7);
    send_frame(8'hD1, 1, 1'b0);
    #1;
    chk(drop_count == 2, "R6 free below MAX_FRAME still drops", int'(drop_count), 2);
    pop_n(1);
    send_frame(8'hE0, 2, 1'b1);
    #1;
    chk(drop_count == 2, "R6 free at MAX_FRAME accepted", int'(drop_count), 2);
    drain();
    compare("R6 threshold frames");
    clear_cnt();
  endtask

  task automatic t_saturate();
    send_frame(8'h01, 8, 1'b1);
    send_frame(8'h09, 8, 1'b1);
    for (int i = 0; i < 9; i++) send_frame(8'hF0 + i, 1, 1'b0);
    #1;
    chk(drop_count == 3'd7, "R7 saturates", int'(drop_count), 7);
    @(negedge clk);
    drop_clr = 1'b1; rx_valid = 1'b1; rx_first = 1'b1; rx_last = 1'b1; rx_data = 8'hFF;
    @(negedge clk);
    drop_clr = 1'b0; rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
    #1;
    chk(drop_count == 3'd1, "R8 clear with concurrent drop", int'(drop_count), 1);
    drain();
    compare("R7 frames kept");
    clear_cnt();
  endtask

  task automatic t_stray();
    tx_ready = 1'b1;
    @(negedge clk);
    rx_valid = 1'b1; rx_first = 1'b0; rx_last = 1'b1; rx_data = 8'h77;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    #1;
    chk(tx_valid == 1'b0, "R9 stray word not offered", int'(tx_valid), 0);
    chk(drop_count == '0, "R9 stray word not counted", int'(drop_count), 0);
    send_frame(8'h55, 2, 1'b1);
    repeat (4) @(negedge clk);
    tx_ready = 1'b0;
    compare("R9 only real frame");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pass();
    t_stall();
    t_overflow();
    t_threshold();
    t_saturate();
    t_stray();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule